// File: doc/BRIEF.md
# PLL Reconfiguration Clock Sequencer

This block retunes a PLL while the rest of the chip keeps running. Software asks for a new integer multiplier and a new input pre-divider with a one-cycle request strobe. The sequencer first checks that the crystal frequency divided by (pre-divider + 1) falls inside the legal reference window. It then moves the system clock select to the alternate oscillator and waits for the clock mux to acknowledge the switch. Next it writes the new settings to the PLL configuration outputs. It lets the PLL settle, waits for a fresh lock, and then returns the select to the PLL. The return also waits for an acknowledge from the mux.

The PLL output frequency is the reference frequency times the multiplier, with the post-divider held at zero. For example, a 25 MHz crystal with a pre-divider of 4 and a multiplier of 64 gives 320 MHz. If lock does not arrive within a programmable number of cycles, the sequence stops with the alternate oscillator still driving the system. A lock level left over from the old settings is never taken as proof of the new ones. The analog PLL, the glitch-free mux and any register access are outside this block.

Top module: `pll_reconfig_seq`

## Requirements
- R1: After synchronous reset, the clock select reads 0 (alternate oscillator). Busy, done and both error flags read 0, and both configuration outputs read 0.
- R2: A request in idle is legal only when 4*(N+1) <= xtal <= 30*(N+1). Here xtal is the crystal frequency in whole MHz and N is the requested pre-divider. An illegal request sets the range error one cycle later. It leaves busy at 0 and leaves the select and the configuration outputs unchanged.
- R3: The configuration outputs never change while the select reads 1. When a legal request arrives with the select at 1, the select drops to 0 first. Programming waits until the switch-acknowledge input has been seen.
- R4: After a completed sequence, the multiplier and pre-divider outputs hold exactly the requested values. They change on a single clock edge per sequence.
- R5: For SETTLE_CYC cycles after the configuration write, the lock input is ignored. With lock held high throughout, the select returns to 1 exactly SETTLE_CYC+1 cycles after the configuration outputs change.
- R6: The select goes back to 1 only after lock is seen. Done pulses for one cycle after the switch-acknowledge for that return, on the same edge that busy falls.
- R7: Suppose lock stays low for timeoutLimit cycles after the settle window. Then the timeout error sets SETTLE_CYC+timeoutLimit cycles after the configuration write, busy falls, the select stays 0 and done stays 0.
- R8: Requests that arrive while busy are ignored. They change neither the final configuration nor the error flags.
- R9: The lock status output equals the lock input delayed by one cycle.
- R10: Any request accepted in idle clears both error flags on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | One-cycle reconfiguration request |
| reqMint | input | MINT_W | Requested integer multiplier |
| reqN | input | N_W | Requested pre-divider (divides by N+1) |
| xtalMhz | input | XTAL_W | Crystal frequency in MHz |
| timeoutLimit | input | TMO_W | Lock wait limit in cycles |
| lockIn | input | 1 | PLL lock indication |
| switchAck | input | 1 | Clock mux acknowledge of a select change |
| selPll | output | 1 | System clock select: 1 PLL, 0 alternate oscillator |
| cfgMint | output | MINT_W | Multiplier driven to the PLL |
| cfgN | output | N_W | Pre-divider driven to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| errRange | output | 1 | Last idle request had an illegal reference |
| errTimeout | output | 1 | Last sequence gave up waiting for lock |
| lockStatus | output | 1 | Registered view of lockIn |

## Verification
The assertions assume that switchAck answers a select change and does not arrive on its own. They also assume that timeoutLimit stays at one or more and does not change during a sequence. The bench acknowledges only on the cycle after it sees the select move. It sets timeoutLimit only while the block is idle. The lock model drops lock when the new configuration appears and raises it a set number of cycles later. One case holds lock high across the write on purpose, to show that stale lock is ignored for the settle window.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TO_ALT,
    ST_PROG,
    ST_SETTLE,
    ST_WAIT_LOCK,
    ST_TO_PLL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptReq;
    logic rejectReq;
    logic selAlt;
    logic selPllSet;
    logic writeCfg;
    logic cntClr;
    logic cntInc;
    logic tmoErr;
    logic doneSet;
  } seqCmd_t;

endpackage

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    refOk,
  input  logic    selPll,
  input  logic    switchAck,
  input  logic    settleDone,
  input  logic    lockTimedOut,
  input  logic    lockIn,
  output seqCmd_t cmd,
  output logic    busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (refOk) begin
            cmd.acceptReq = 1'b1;
            if (selPll) begin
              cmd.selAlt = 1'b1;
              nextState  = ST_TO_ALT;
            end else begin
              nextState  = ST_PROG;
            end
          end else begin
            cmd.rejectReq = 1'b1;
          end
        end
      end
      ST_TO_ALT: begin
        if (switchAck) nextState = ST_PROG;
      end
      ST_PROG: begin
        cmd.writeCfg = 1'b1;
        cmd.cntClr   = 1'b1;
        nextState    = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settleDone) begin
          cmd.cntClr = 1'b1;
          nextState  = ST_WAIT_LOCK;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_WAIT_LOCK: begin
        if (lockIn) begin
          cmd.selPllSet = 1'b1;
          nextState     = ST_TO_PLL;
        end else if (lockTimedOut) begin
          cmd.tmoErr = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_TO_PLL: begin
        if (switchAck) begin
          cmd.doneSet = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int MINT_W     = 10,
  parameter int N_W        = 5,
  parameter int XTAL_W     = 6,
  parameter int TMO_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int REF_MIN    = 4,
  parameter int REF_MAX    = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCmd_t           cmd,
  input  logic [MINT_W-1:0] reqMint,
  input  logic [N_W-1:0]    reqN,
  input  logic [XTAL_W-1:0] xtalMhz,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              lockIn,
  output logic              refOk,
  output logic              settleDone,
  output logic              lockTimedOut,
  output logic              selPll,
  output logic [MINT_W-1:0] cfgMint,
  output logic [N_W-1:0]    cfgN,
  output logic              errRange,
  output logic              errTimeout,
  output logic              done,
  output logic              lockStatus
);

  localparam int PROD_W = ((N_W + 6) > XTAL_W) ? (N_W + 6) : XTAL_W;
  localparam int CNT_W  = TMO_W;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  logic [PROD_W-1:0] divisor, loBound, hiBound, xtalExt;
  logic [MINT_W-1:0] pendMint;
  logic [N_W-1:0]    pendN;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    cntNext;

  // legal iff REF_MIN*(N+1) <= xtal <= REF_MAX*(N+1), no divider needed
  always_comb begin
    divisor = PROD_W'(reqN) + PROD_W'(1);
    loBound = divisor * PROD_W'(REF_MIN);
    hiBound = divisor * PROD_W'(REF_MAX);
    xtalExt = PROD_W'(xtalMhz);
    refOk   = (xtalExt >= loBound) && (xtalExt <= hiBound);
  end

  assign cntNext      = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign settleDone   = (cnt == SETTLE_LAST);
  assign lockTimedOut = (cntNext >= {1'b0, timeoutLimit});

  always_ff @(posedge clk) begin
    if (rst) begin
      pendMint   <= '0;
      pendN      <= '0;
      cfgMint    <= '0;
      cfgN       <= '0;
      cnt        <= '0;
      selPll     <= 1'b0;
      errRange   <= 1'b0;
      errTimeout <= 1'b0;
      done       <= 1'b0;
      lockStatus <= 1'b0;
    end else begin
      lockStatus <= lockIn;
      done       <= cmd.doneSet;
      if (cmd.acceptReq) begin
        pendMint <= reqMint;
        pendN    <= reqN;
      end
      if (cmd.writeCfg) begin
        cfgMint <= pendMint;
        cfgN    <= pendN;
      end
      if (cmd.cntClr)      cnt <= '0;
      else if (cmd.cntInc) cnt <= cntNext[CNT_W-1:0];
      if (cmd.selAlt)         selPll <= 1'b0;
      else if (cmd.selPllSet) selPll <= 1'b1;
      if (cmd.acceptReq || cmd.rejectReq) begin
        errRange   <= cmd.rejectReq;
        errTimeout <= 1'b0;
      end else if (cmd.tmoErr) begin
        errTimeout <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pll_seq_pkg::*;
#(
  parameter int MINT_W     = 10,
  parameter int N_W        = 5,
  parameter int XTAL_W     = 6,
  parameter int TMO_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [MINT_W-1:0] reqMint,
  input  logic [N_W-1:0]    reqN,
  input  logic [XTAL_W-1:0] xtalMhz,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              lockIn,
  input  logic              switchAck,
  output logic              selPll,
  output logic [MINT_W-1:0] cfgMint,
  output logic [N_W-1:0]    cfgN,
  output logic              busy,
  output logic              done,
  output logic              errRange,
  output logic              errTimeout,
  output logic              lockStatus
);

  seqCmd_t cmd;
  logic    refOk, settleDone, lockTimedOut;

  pll_seq_ctrl ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .refOk(refOk),
    .selPll(selPll), .switchAck(switchAck), .settleDone(settleDone),
    .lockTimedOut(lockTimedOut), .lockIn(lockIn), .cmd(cmd), .busy(busy)
  );

  pll_seq_dp #(
    .MINT_W(MINT_W), .N_W(N_W), .XTAL_W(XTAL_W),
    .TMO_W(TMO_W), .SETTLE_CYC(SETTLE_CYC)
  ) dp_i (
    .clk(clk), .rst(rst), .cmd(cmd), .reqMint(reqMint), .reqN(reqN),
    .xtalMhz(xtalMhz), .timeoutLimit(timeoutLimit), .lockIn(lockIn),
    .refOk(refOk), .settleDone(settleDone), .lockTimedOut(lockTimedOut),
    .selPll(selPll), .cfgMint(cfgMint), .cfgN(cfgN), .errRange(errRange),
    .errTimeout(errTimeout), .done(done), .lockStatus(lockStatus)
  );

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int MINT_W = 10,
  parameter int N_W    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              busy,
  input logic              selPll,
  input logic [MINT_W-1:0] cfgMint,
  input logic [N_W-1:0]    cfgN,
  input logic              done,
  input logic              errRange,
  input logic              errTimeout,
  input logic              lockIn,
  input logic              lockStatus
);

  // R3: configuration may only move while the alternate source is selected
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !($stable(cfgMint) && $stable(cfgN)) |-> !selPll);

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: completion only with the PLL selected and the sequencer idle
  p_done_on_pll_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (selPll && !busy));

  // R7: a timeout leaves the alternate oscillator in charge
  p_tmo_alt_r7: assert property (@(posedge clk) disable iff (rst)
    errTimeout |-> !selPll);

  // R2 / R8: a range error only comes from a request seen in idle
  p_range_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(errRange) |-> ($past(reqValid) && !$past(busy)));

  // R9: lock status is the lock input one cycle later
  p_lock_view_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lockStatus == $past(lockIn)));

endmodule

bind pll_reconfig_seq pll_seq_chk #(.MINT_W(MINT_W), .N_W(N_W)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .busy(busy), .selPll(selPll),
  .cfgMint(cfgMint), .cfgN(cfgN), .done(done), .errRange(errRange),
  .errTimeout(errTimeout), .lockIn(lockIn), .lockStatus(lockStatus)
);

// File: tb/pll_reconfig_seq_tb.sv
`timescale 1ns/1ps
module pll_reconfig_seq_tb_top;

  localparam int MINT_W = 10;
  localparam int N_W    = 5;
  localparam int XTAL_W = 6;
  localparam int TMO_W  = 16;
  localparam int SETTLE = 4;

  typedef struct packed {
    logic [XTAL_W-1:0] x;
    logic [N_W-1:0]    n;
    logic [MINT_W-1:0] m;
    logic [3:0]        dly;
    logic              expOk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{6'd25, 5'd4, 10'd64,  4'd2, 1'b1},
    '{6'd16, 5'd0, 10'd30,  4'd3, 1'b1},
    '{6'd24, 5'd2, 10'd40,  4'd1, 1'b1},
    '{6'd18, 5'd8, 10'd160, 4'd2, 1'b0},
    '{6'd40, 5'd0, 10'd12,  4'd2, 1'b0},
    '{6'd30, 5'd0, 10'd16,  4'd5, 1'b1},
    '{6'd31, 5'd0, 10'd16,  4'd2, 1'b0},
    '{6'd8,  5'd1, 10'd80,  4'd4, 1'b1},
    '{6'd7,  5'd1, 10'd80,  4'd2, 1'b0},
    '{6'd60, 5'd1, 10'd16,  4'd6, 1'b1},
    '{6'd61, 5'd1, 10'd16,  4'd2, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [MINT_W-1:0] reqMint = '0;
  logic [N_W-1:0]    reqN = '0;
  logic [XTAL_W-1:0] xtalMhz = '0;
  logic [TMO_W-1:0]  timeoutLimit = 16'd200;
  logic lockIn = 1'b0;
  logic switchAck = 1'b0;
  logic selPll, busy, done, errRange, errTimeout, lockStatus;
  logic [MINT_W-1:0] cfgMint;
  logic [N_W-1:0]    cfgN;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pll_reconfig_seq #(
    .MINT_W(MINT_W), .N_W(N_W), .XTAL_W(XTAL_W), .TMO_W(TMO_W), .SETTLE_CYC(SETTLE)
  ) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqMint(reqMint), .reqN(reqN),
    .xtalMhz(xtalMhz), .timeoutLimit(timeoutLimit), .lockIn(lockIn),
    .switchAck(switchAck), .selPll(selPll), .cfgMint(cfgMint), .cfgN(cfgN),
    .busy(busy), .done(done), .errRange(errRange), .errTimeout(errTimeout),
    .lockStatus(lockStatus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // results of the last sequence
  int wrC, riseC, endC, errAt0, busyAt0, tmoAt0, orderOk, doneEnd, tmoEnd;

  task automatic runReq(input int x, input int n, input int m, input int dly, input bit inject);
    logic selPrev;
    logic [MINT_W+N_W-1:0] cfgPrev;
    int lockCnt;
    wrC = -1; riseC = -1; endC = -1; orderOk = 1; lockCnt = 0;
    selPrev = selPll;
    cfgPrev = {cfgMint, cfgN};
    xtalMhz = XTAL_W'(x); reqN = N_W'(n); reqMint = MINT_W'(m);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (c == 0) begin
        errAt0 = errRange; busyAt0 = busy; tmoAt0 = errTimeout;
      end
      switchAck = (selPll != selPrev);
      if (selPll && !selPrev) riseC = c;
      selPrev = selPll;
      if ({cfgMint, cfgN} != cfgPrev) begin
        wrC = c;
        if (selPll) orderOk = 0;
        if (dly > 0) begin lockIn = 1'b0; lockCnt = dly; end
      end else if (lockCnt > 0) begin
        lockCnt--;
        if (lockCnt == 0) lockIn = 1'b1;
      end
      cfgPrev = {cfgMint, cfgN};
      if (inject && c == 3) begin
        xtalMhz = 6'd63; reqN = '0; reqMint = 10'd1; reqValid = 1'b1;
      end
      if (inject && c == 4) reqValid = 1'b0;
      if (!busy) begin
        endC = c; doneEnd = done; tmoEnd = errTimeout;
        break;
      end
      @(negedge clk);
    end
    switchAck = 1'b0;
    reqValid  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 selPll", selPll, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 errRange", errRange, 0);
    chk("R1 errTimeout", errTimeout, 0);
    chk("R1 cfg", int'({cfgMint, cfgN}), 0);

    // R9 lock status follows input one cycle late
    lockIn = 1'b1;
    @(negedge clk);
    chk("R9 lock high", lockStatus, 1);
    lockIn = 1'b0;
    @(negedge clk);
    chk("R9 lock low", lockStatus, 0);
    lockIn = 1'b1;

    // table walk: R2 legality, R3 ordering, R4 values, R6 completion
    for (int i = 0; i < NV; i++) begin
      real refMhz;
      bit ok;
      logic preSel;
      logic [MINT_W+N_W-1:0] preCfg;
      refMhz = real'(VECS[i].x) / real'(VECS[i].n + 1);
      ok = (refMhz >= 4.0) && (refMhz <= 30.0);
      chk("R2 table expectation", int'(ok), int'(VECS[i].expOk));
      preSel = selPll;
      preCfg = {cfgMint, cfgN};
      runReq(VECS[i].x, VECS[i].n, VECS[i].m, VECS[i].dly, 1'b0);
      if (ok) begin
        chk("R2 legal no error", errAt0, 0);
        chk("R2 legal accepted", busyAt0, 1);
        chk("R3 cfg moved with alt selected", orderOk, 1);
        chk("R4 mint", cfgMint, VECS[i].m);
        chk("R4 n", cfgN, VECS[i].n);
        chk("R6 done", doneEnd, 1);
        chk("R6 back on pll", selPll, 1);
      end else begin
        chk("R2 illegal error", errAt0, 1);
        chk("R2 illegal not busy", busyAt0, 0);
        chk("R2 illegal cfg kept", int'({cfgMint, cfgN}), int'(preCfg));
        chk("R2 illegal sel kept", selPll, preSel);
      end
    end

    // R5 stale lock ignored through the settle window
    lockIn = 1'b1;
    runReq(25, 4, 96, 0, 1'b0);
    chk("R5 settle delay", riseC - wrC, SETTLE + 1);
    chk("R6 done after stale-lock run", doneEnd, 1);

    // R7 timeout
    lockIn = 1'b0;
    timeoutLimit = 16'd20;
    runReq(20, 0, 24, 0, 1'b0);
    chk("R7 timeout flag", tmoEnd, 1);
    chk("R7 timeout cycle", endC - wrC, SETTLE + 20);
    chk("R7 stays alt", selPll, 0);
    chk("R7 no done", doneEnd, 0);
    timeoutLimit = 16'd200;

    // R10 accepted request clears the timeout error
    runReq(10, 0, 48, 3, 1'b0);
    chk("R10 errors cleared", tmoAt0, 0);
    chk("R10 completes", doneEnd, 1);

    // R8 request during busy ignored
    runReq(16, 0, 30, 5, 1'b1);
    chk("R8 mint kept", cfgMint, 30);
    chk("R8 n kept", cfgN, 0);
    chk("R8 no range error", errRange, 0);
    chk("R8 completes", doneEnd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule